// File: doc/BRIEF.md
# Filterbank Host Register Block with Pulse-Per-Second Timing

This block sits between a host command channel and a 16-channel frequency filterbank. Each host access is a single 32-bit command word. The block splits that word into a board address, a register address, a block address, a read-only flag and a 16-bit write value. It acts only on words addressed to its own board and block. Every access it accepts returns one register value on the read bus one clock later.

The block holds a control register, sixteen per-channel threshold registers and three sticky event flags. The control fields drive these outputs:
- the monitor channel selector,
- the input source selector,
- the frequency word of the internal test generator.

A channel register reads back as the channel's measured power together with its threshold. The event flags clear themselves when the host reads status.

The block also contains a once-per-second timing strobe. It free-runs on the sample clock. While sync is enabled in the control register, it re-aligns to the rising edge of an external pulse.

Top module: `fbhr_top`

## Requirements
- R1: Field positions in `cmd_word` are fixed: bits 31:27 board address, 26:21 register address, 18:17 block address, bit 16 read-only flag, bits 15:0 write value. An access is accepted only when the board address is 1 and the block address is 0. Any other access writes nothing, and `rd_data` becomes zero one cycle later.
- R2: For an accepted access presented with `cmd_valid` in cycle t, `rd_data` in cycle t+1 holds the addressed register's value as it was before any write in cycle t. `rd_data` is zero after reset.
- R3: An accepted access with the read-only flag set modifies neither the control register nor any threshold register.
- R4: The block decodes 32 register slots. Only slot 0 and slots 16 to 31 exist. Every other slot, including register addresses 32 to 63, reads as zero, and writes to them change nothing.
- R5: A write to slot 0 stores the 16-bit control value. Its fields drive the outputs as follows:
  - bits 3:0 drive `mon_chan`;
  - bit 4 drives `src_sel` (0 = converter input, 1 = internal generator);
  - bit 5 enables external sync;
  - bits 15:6 drive `gen_freq`, in units of 0.5 MHz.
  All fields are zero after reset.
- R6: A read of slot 0 returns the status word. Its layout is:
  - bits 8:0 are control bits 8:0;
  - bit 9 is the overflow flag;
  - bit 10 is the power-ready flag;
  - bit 15 is the power-overflow flag;
  - all other bits are zero.
- R7: A one-cycle pulse on `ovf_evt`, `pwr_rdy_evt` or `pwr_ovf_evt` sets its flag. The flag stays set until an accepted access to slot 0, which returns the flag and clears it.
- R8: If an event pulse arrives in the same cycle as a status access, that access returns the flag's old value and the flag is left set.
- R9: Slot 16+k (k = 0..15) stores the 16-bit write value as the threshold of channel k, which appears on `thr_level[16k+15:16k]`. A read of slot 16+k returns {`pwr_level[16k+15:16k]`, threshold k}.
- R10: With sync disabled, `pps_out` is a one-cycle strobe every PPS_PERIOD clock cycles (default 128,000,000).
- R11: With sync enabled, a rising edge on `ext_pps` raises `pps_out` on the third clock edge after it is sampled: two synchronizer flops, then the strobe register. The period counter restarts at that strobe, so the next strobe follows PPS_PERIOD cycles later.
- R12: With sync disabled, edges on `ext_pps` have no effect on the phase or period of `pps_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 32 | Host command word |
| rd_data | output | 32 | Value returned by the last accepted access |
| ovf_evt | input | 1 | Overflow event pulse |
| pwr_rdy_evt | input | 1 | Power-ready event pulse |
| pwr_ovf_evt | input | 1 | Power-overflow event pulse |
| pwr_level | input | 256 | Per-channel power readings, 16 bits each |
| ext_pps | input | 1 | External once-per-second pulse, asynchronous |
| mon_chan | output | 4 | Monitor channel select |
| src_sel | output | 1 | Input source select |
| gen_freq | output | 10 | Test generator frequency word |
| thr_level | output | 256 | Per-channel thresholds, 16 bits each |
| pps_out | output | 1 | Internal once-per-second strobe |

## Verification
The following rules are checked by assertions on every cycle:
- read-only accesses leave the control and threshold registers untouched;
- foreign accesses produce a zero read;
- an event pulse always leaves its flag set one cycle later;
- a status read with no event leaves all flags clear;
- the strobe is one cycle wide;
- with sync off, the strobe fires only at counter wrap;
- an accepted external edge restarts the counter.

Three things can only be shown by the bench's scenarios: the exact status and channel word layouts, the zero reads of empty slots, and the cycle distances between strobes. For the strobe distances, the bench measures the three-edge latency from the external edge and the full period that follows, and confirms that an external edge with sync off leaves the free-running phase unchanged.

// File: rtl/fbhr_pkg.sv
package fbhr_pkg;

    localparam int CMD_W    = 32;
    localparam int DATA_W   = 16;
    localparam int SLOT_W   = 5;

    // field positions inside the host command word
    localparam int BRD_LSB  = 27;
    localparam int REG_LSB  = 21;
    localparam int BLK_LSB  = 17;
    localparam int RO_BIT   = 16;

    typedef struct packed {
        logic [4:0]        board;
        logic [5:0]        reg_a;
        logic [1:0]        blk;
        logic              rd_only;
        logic [DATA_W-1:0] wval;
    } host_cmd_t;

    function automatic host_cmd_t split_cmd(input logic [CMD_W-1:0] w);
        host_cmd_t c;
        c.board   = w[BRD_LSB +: 5];
        c.reg_a   = w[REG_LSB +: 6];
        c.blk     = w[BLK_LSB +: 2];
        c.rd_only = w[RO_BIT];
        c.wval    = w[DATA_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/fbhr_cmd_decode.sv
module fbhr_cmd_decode
    import fbhr_pkg::*;
#(
    parameter int BOARD_ID = 1,
    parameter int BLOCK_ID = 0
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              hit,
    output logic              wr_en,
    output logic              slot_ok,
    output logic [SLOT_W-1:0] slot,
    output logic [DATA_W-1:0] wval
);
    host_cmd_t c;

    always_comb begin
        c       = split_cmd(cmd_word);
        hit     = cmd_valid && (c.board == 5'(BOARD_ID)) && (c.blk == 2'(BLOCK_ID));
        wr_en   = hit && !c.rd_only;
        slot_ok = (c.reg_a[5] == 1'b0);
        slot    = c.reg_a[SLOT_W-1:0];
        wval    = c.wval;
    end
endmodule

// File: rtl/fbhr_event_flags.sv
module fbhr_event_flags #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] evt,
    input  logic           clr,
    output logic [NEV-1:0] flags
);
    typedef struct packed {
        logic [NEV-1:0] flg;
    } ev_state_t;

    ev_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // a clear never beats an event arriving in the same cycle
        st_d.flg = (clr ? '0 : st_q.flg) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/fbhr_pps_gen.sv
module fbhr_pps_gen #(
    parameter int PPS_PERIOD = 128_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic ext_pps,
    output logic pps_out
);
    localparam int CW = (PPS_PERIOD > 1) ? $clog2(PPS_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PPS_PERIOD - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [CW-1:0] cnt;
        logic          pps;
    } pps_state_t;

    pps_state_t st_q, st_d;
    logic       ext_rise;
    logic       wrap;
    logic       realign;

    always_comb begin
        st_d     = st_q;
        ext_rise = st_q.s2 && !st_q.s3;
        wrap     = (st_q.cnt == LAST);
        realign  = sync_en && ext_rise;

        st_d.s1  = ext_pps;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        st_d.cnt = (wrap || realign) ? '0 : st_q.cnt + 1'b1;
        st_d.pps = wrap || realign;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pps_out = st_q.pps;

    // R10
    pps_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pps |=> !st_q.pps);

    // R12
    nosync_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && st_q.cnt != LAST) |=> !st_q.pps);

    // R11
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && st_q.s2 && !st_q.s3) |=> (st_q.pps && st_q.cnt == '0));
endmodule

// File: rtl/fbhr_top.sv
module fbhr_top
    import fbhr_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int PPS_PERIOD = 128_000_000,
    parameter int BOARD_ID   = 1,
    parameter int BLOCK_ID   = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [CMD_W-1:0]      cmd_word,
    output logic [CMD_W-1:0]      rd_data,
    input  logic                  ovf_evt,
    input  logic                  pwr_rdy_evt,
    input  logic                  pwr_ovf_evt,
    input  logic [NCH*DATA_W-1:0] pwr_level,
    input  logic                  ext_pps,
    output logic [3:0]            mon_chan,
    output logic                  src_sel,
    output logic [9:0]            gen_freq,
    output logic [NCH*DATA_W-1:0] thr_level,
    output logic                  pps_out
);
    localparam int THR_BASE = 16;
    localparam int IW       = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0]          ctrl;
        logic [NCH-1:0][DATA_W-1:0] thr;
        logic [CMD_W-1:0]           rd;
    } reg_state_t;

    reg_state_t st_q, st_d;

    logic              hit, wr_en, slot_ok, clr;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] wval;
    logic [2:0]        flags;
    logic [CMD_W-1:0]  rd_val;
    logic [IW-1:0]     tidx;
    logic              is_thr;
    logic [NCH-1:0][DATA_W-1:0] pwr_arr;

    assign pwr_arr = pwr_level;

    fbhr_cmd_decode #(.BOARD_ID(BOARD_ID), .BLOCK_ID(BLOCK_ID)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .hit       (hit),
        .wr_en     (wr_en),
        .slot_ok   (slot_ok),
        .slot      (slot),
        .wval      (wval)
    );

    assign clr = hit && slot_ok && (slot == '0);

    fbhr_event_flags #(.NEV(3)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   ({pwr_ovf_evt, pwr_rdy_evt, ovf_evt}),
        .clr   (clr),
        .flags (flags)
    );

    fbhr_pps_gen #(.PPS_PERIOD(PPS_PERIOD)) u_pps (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (st_q.ctrl[5]),
        .ext_pps (ext_pps),
        .pps_out (pps_out)
    );

    always_comb begin
        st_d   = st_q;
        is_thr = slot_ok && (int'(slot) >= THR_BASE) && (int'(slot) < THR_BASE + NCH);
        tidx   = IW'(int'(slot) - THR_BASE);
        rd_val = '0;
        if (slot_ok && slot == '0)
            rd_val = {16'h0, flags[2], 4'h0, flags[1], flags[0], st_q.ctrl[8:0]};
        else if (is_thr)
            rd_val = {pwr_arr[tidx], st_q.thr[tidx]};

        if (cmd_valid) begin
            st_d.rd = hit ? rd_val : '0;
        end
        if (wr_en && slot_ok && slot == '0)
            st_d.ctrl = wval;
        if (wr_en && is_thr)
            st_d.thr[tidx] = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd;
    assign mon_chan  = st_q.ctrl[3:0];
    assign src_sel   = st_q.ctrl[4];
    assign gen_freq  = st_q.ctrl[15:6];
    assign thr_level = st_q.thr;

    // R3
    ro_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[RO_BIT]) |=> ($stable(st_q.ctrl) && $stable(st_q.thr)));

    // R1
    foreign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !hit) |=> (rd_data == '0));
endmodule

// File: tb/fbhr_top_test.sv
module fbhr_top_test;
    localparam int NCH = 16;
    localparam int PER = 40;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cmd_valid = 0;
    logic [31:0]   cmd_word = '0;
    logic [31:0]   rd_data;
    logic          ovf_evt = 0, pwr_rdy_evt = 0, pwr_ovf_evt = 0;
    logic [NCH*16-1:0] pwr_level;
    logic          ext_pps = 0;
    logic [3:0]    mon_chan;
    logic          src_sel;
    logic [9:0]    gen_freq;
    logic [NCH*16-1:0] thr_level;
    logic          pps_out;

    int errs = 0, checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        took = 0;

    // bench model of the register contents
    logic [15:0] m_ctrl = '0;
    logic [15:0] m_thr [NCH];
    logic [2:0]  m_flg = '0;

    always #2 clk = ~clk;   // 250 MHz

    fbhr_top #(.NCH(NCH), .PPS_PERIOD(PER)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rd_data(rd_data), .ovf_evt(ovf_evt), .pwr_rdy_evt(pwr_rdy_evt),
        .pwr_ovf_evt(pwr_ovf_evt), .pwr_level(pwr_level), .ext_pps(ext_pps),
        .mon_chan(mon_chan), .src_sel(src_sel), .gen_freq(gen_freq),
        .thr_level(thr_level), .pps_out(pps_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: one expected read per accepted command
    always @(posedge clk) took <= cmd_valid;
    always @(negedge clk) begin
        if (took && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    function automatic logic [31:0] status_word(input logic [2:0] f, input logic [15:0] c);
        return {16'h0, f[2], 4'h0, f[1], f[0], c[8:0]};
    endfunction

    // driver: issues one command, predicts its read value, updates the model
    task automatic access(input string tag, input logic [4:0] brd, input logic [5:0] ra,
                          input logic [1:0] blk, input logic ro, input logic [15:0] wv,
                          input logic [2:0] evt);
        logic [31:0] e;
        bit ok;
        ok = (brd == 5'd1) && (blk == 2'd0);
        e  = '0;
        if (ok && ra == 6'd0) e = status_word(m_flg, m_ctrl);
        else if (ok && ra >= 6'd16 && ra < 6'd32)
            e = {pwr_level[(ra-16)*16 +: 16], m_thr[ra-16]};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cmd_word  = {brd, ra, 2'b00, blk, ro, wv};
        cmd_valid = 1;
        {pwr_ovf_evt, pwr_rdy_evt, ovf_evt} = evt;
        if (ok && ra == 6'd0) m_flg = evt; else m_flg = m_flg | evt;
        if (ok && !ro && ra == 6'd0) m_ctrl = wv;
        if (ok && !ro && ra >= 6'd16 && ra < 6'd32) m_thr[ra-16] = wv;
        @(negedge clk);
        cmd_valid = 0;
        {pwr_ovf_evt, pwr_rdy_evt, ovf_evt} = 3'b000;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [2:0] evt);
        {pwr_ovf_evt, pwr_rdy_evt, ovf_evt} = evt;
        m_flg = m_flg | evt;
        @(negedge clk);
        {pwr_ovf_evt, pwr_rdy_evt, ovf_evt} = 3'b000;
        @(negedge clk);
    endtask

    task automatic wait_pps(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pps_out && n < 4 * PER);
    endtask

    initial begin
        int n;
        for (int k = 0; k < NCH; k++) begin
            pwr_level[k*16 +: 16] = 16'h0100 + 16'(k);
            m_thr[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R2 / R5 reset state
        chk("R2 reset rd_data", rd_data, 32'h0);
        chk("R5 reset ctrl outputs", {17'h0, gen_freq, src_sel, mon_chan}, 32'h0);
        chk("R9 reset thresholds", thr_level[31:0], 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R5 control fields: value C2D7 -> mon 7, src 1, sync 0, freq 30B
        access("R5 ctrl write", 5'd1, 6'd0, 2'd0, 1'b0, 16'hC2D7, 3'b0);
        chk("R5 mon_chan", {28'h0, mon_chan}, 32'h7);
        chk("R5 src_sel", {31'h0, src_sel}, 32'h1);
        chk("R5 gen_freq", {22'h0, gen_freq}, 32'h30B);
        access("R6 status echo", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);

        // R3 read-only write attempt
        access("R3 ro access", 5'd1, 6'd0, 2'd0, 1'b1, 16'hFFFF, 3'b0);
        chk("R3 ctrl kept", {28'h0, mon_chan}, 32'h7);
        access("R3 ro thr", 5'd1, 6'd20, 2'd0, 1'b1, 16'hAAAA, 3'b0);
        chk("R3 thr kept", {16'h0, thr_level[4*16 +: 16]}, 32'h0);

        // R1 foreign board / block
        access("R1 other board", 5'd2, 6'd0, 2'd0, 1'b0, 16'h0001, 3'b0);
        access("R1 other block", 5'd1, 6'd0, 2'd1, 1'b0, 16'h0002, 3'b0);
        chk("R1 ctrl untouched", {28'h0, mon_chan}, 32'h7);

        // R9 thresholds
        access("R9 thr3 write", 5'd1, 6'd19, 2'd0, 1'b0, 16'h1234, 3'b0);
        chk("R9 thr3 out", {16'h0, thr_level[3*16 +: 16]}, 32'h1234);
        access("R9 thr3 read", 5'd1, 6'd19, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R9 thr15 write", 5'd1, 6'd31, 2'd0, 1'b0, 16'hBEEF, 3'b0);
        access("R9 thr15 read", 5'd1, 6'd31, 2'd0, 1'b0, 16'hBEEF, 3'b0);
        access("R9 thr0 write", 5'd1, 6'd16, 2'd0, 1'b0, 16'h00C3, 3'b0);
        access("R2 thr0 prior value", 5'd1, 6'd16, 2'd0, 1'b0, 16'h0C30, 3'b0);

        // R4 empty slots
        access("R4 slot5 write", 5'd1, 6'd5, 2'd0, 1'b0, 16'h5555, 3'b0);
        access("R4 slot5 read", 5'd1, 6'd5, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R4 addr48 write", 5'd1, 6'd48, 2'd0, 1'b0, 16'h1111, 3'b0);
        chk("R4 thr0 untouched", {16'h0, thr_level[15:0]}, 32'h0C30);
        chk("R4 ctrl untouched", {28'h0, mon_chan}, 32'h7);

        // R7 sticky flags, clear on status read
        pulse_evt(3'b001);
        access("R7 ovf set", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R7 ovf cleared", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);
        pulse_evt(3'b010);
        pulse_evt(3'b100);
        access("R7 rdy and povf set", 5'd1, 6'd19, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R6 status flags", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R7 all cleared", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);

        // R8 event coinciding with status read
        access("R8 read with event", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b100);
        access("R8 event kept", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);
        access("R8 cleared after", 5'd1, 6'd0, 2'd0, 1'b1, 16'h0, 3'b0);

        // R10 free-running period and width
        wait_pps(n);
        wait_pps(n);
        chk("R10 period", n, PER);
        @(negedge clk);
        chk("R10 width", {31'h0, pps_out}, 32'h0);
        wait_pps(n);

        // R12 sync disabled: ext edge ignored
        ext_pps = 1;
        wait_pps(n);
        chk("R12 phase unchanged", n, PER);
        ext_pps = 0;
        repeat (4) @(negedge clk);

        // R11 sync enabled (ctrl bit 5)
        access("R11 enable sync", 5'd1, 6'd0, 2'd0, 1'b0, 16'hC2F7, 3'b0);
        wait_pps(n);
        repeat (10) @(negedge clk);
        ext_pps = 1;
        wait_pps(n);
        chk("R11 edge latency", n, 3);
        wait_pps(n);
        chk("R11 restart period", n, PER);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R2 pending reads", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule